// File: doc/BRIEF.md
# Programming Cycle Timer with Acknowledge Gating

This block times the self-driven programming cycle of a serial memory slave. A write transfer that has carried at least one data byte and is closed by a stop condition starts the cycle. For its whole length the slave takes no notice of bus events and does not acknowledge its own address. A host learns that the cycle is over by sending a start and the address word again and again until an acknowledge comes back. The bus decoder and the address engine sit outside this block. They report start, stop, received data bytes and address matches as one-cycle pulses. In return the block gives them a busy flag, an acknowledge gate and the acknowledge drive itself.

The cycle length is the parameter `CYCLES`, counted in system clocks. The storage array sees the cycle as a one-cycle commit-start pulse, issued on the clock after the stop, and a one-cycle commit-done pulse when the cycle ends.

Top module: `write_cycle_timer`

## Requirements
- R1: After reset, `busy`, `commitStart`, `commitDone` and `sdaAckLow` are 0 and `ackGate` is 1.
- R2: A `stopCond` pulse sampled while idle, after at least one `byteWritten` pulse since the last start or stop, raises `busy` and `commitStart` at the following clock edge. `commitStart` stays high for exactly one cycle.
- R3: Once raised, `busy` stays high for exactly `CYCLES` clock cycles and then falls.
- R4: `commitDone` is high for exactly one cycle, in the first cycle after `busy` falls, and at no other time.
- R5: A stop that closes a transfer with no data byte since the last start or stop starts no cycle.
- R6: While `busy` is high, `ackGate` is 0 and `sdaAckLow` stays 0 even when `addrMatch` is 1, so the host sees a not-acknowledge.
- R7: While idle, `ackGate` is 1 and `sdaAckLow` (1 = pull the data line low) follows `addrMatch` in the same cycle.
- R8: Start, stop and data-byte pulses that arrive while busy are ignored. They neither lengthen nor restart the running cycle, and they do not arm a later stop.
- R9: A start condition discards data bytes received since the previous start or stop. A stop that follows with no new byte starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startCond | input | 1 | One-cycle pulse: start condition seen on the bus |
| stopCond | input | 1 | One-cycle pulse: stop condition seen on the bus |
| byteWritten | input | 1 | One-cycle pulse: a data byte of a write transfer was accepted |
| addrMatch | input | 1 | Address engine wants to acknowledge a matching address word |
| busy | output | 1 | Programming cycle in progress |
| ackGate | output | 1 | 1 when the slave may acknowledge its address |
| sdaAckLow | output | 1 | Acknowledge drive, 1 pulls the data line low |
| commitStart | output | 1 | One-cycle pulse: begin committing data to storage |
| commitDone | output | 1 | One-cycle pulse: commit finished |

## Verification
The bench builds the timer with `CYCLES` = 7. That keeps every cycle short, so the bench can cover a full programming cycle, polling during it, stray bus events inside it and the first poll after it several times over in a few hundred clocks. A random phase then mixes starts, stops, bytes and address matches, which places stops close to the end of a cycle and right after one. At that length the exact busy width and the timing of the done pulse are still checked against the parameter.

// File: rtl/wct_pkg.sv
package wct_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } wctState_t;

  typedef struct packed {
    logic load;
    logic tick;
  } wctCmd_t;
endpackage

// File: rtl/wct_count.sv
module wct_count
  import wct_pkg::*;
#(
  parameter int CYCLES = 5000
) (
  input  logic    clk,
  input  logic    rstN,
  input  wctCmd_t cmd,
  output logic    lastTick
);
  localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
  localparam logic [CW-1:0] LOAD_VAL = CW'(CYCLES - 1);

  logic [CW-1:0] remaining;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remaining <= '0;
    end else if (cmd.load) begin
      remaining <= LOAD_VAL;
    end else if (cmd.tick && remaining != '0) begin
      remaining <= remaining - 1'b1;
    end
  end

  assign lastTick = (remaining == '0);
endmodule

// File: rtl/wct_ctrl.sv
module wct_ctrl
  import wct_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startCond,
  input  logic    stopCond,
  input  logic    byteWritten,
  input  logic    addrMatch,
  input  logic    lastTick,
  output wctCmd_t cmd,
  output logic    busy,
  output logic    ackGate,
  output logic    sdaAckLow,
  output logic    commitStart,
  output logic    commitDone
);
  wctState_t state;
  logic      pending;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      pending     <= 1'b0;
      commitStart <= 1'b0;
      commitDone  <= 1'b0;
    end else begin
      commitStart <= 1'b0;
      commitDone  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (stopCond) begin
            pending <= 1'b0;
            if (pending) begin
              state       <= ST_RUN;
              commitStart <= 1'b1;
            end
          end else if (startCond) begin
            pending <= 1'b0;
          end else if (byteWritten) begin
            pending <= 1'b1;
          end
        end
        ST_RUN: begin
          if (lastTick) begin
            state      <= ST_IDLE;
            commitDone <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd.load = (state == ST_IDLE) && stopCond && pending;
    cmd.tick = (state == ST_RUN);
  end

  assign busy      = (state == ST_RUN);
  assign ackGate   = !busy;
  assign sdaAckLow = addrMatch && ackGate;
endmodule

// File: rtl/write_cycle_timer.sv
module write_cycle_timer
  import wct_pkg::*;
#(
  parameter int CYCLES = 5000
) (
  input  logic clk,
  input  logic rstN,
  input  logic startCond,
  input  logic stopCond,
  input  logic byteWritten,
  input  logic addrMatch,
  output logic busy,
  output logic ackGate,
  output logic sdaAckLow,
  output logic commitStart,
  output logic commitDone
);
  wctCmd_t cmd;
  logic    lastTick;

  wct_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .startCond(startCond), .stopCond(stopCond),
    .byteWritten(byteWritten), .addrMatch(addrMatch),
    .lastTick(lastTick), .cmd(cmd),
    .busy(busy), .ackGate(ackGate), .sdaAckLow(sdaAckLow),
    .commitStart(commitStart), .commitDone(commitDone)
  );

  wct_count #(.CYCLES(CYCLES)) u_count (
    .clk(clk), .rstN(rstN), .cmd(cmd), .lastTick(lastTick)
  );
endmodule

// File: rtl/wct_checker.sv
module wct_checker #(
  parameter int CYCLES = 5000
) (
  input logic clk,
  input logic rstN,
  input logic addrMatch,
  input logic busy,
  input logic ackGate,
  input logic sdaAckLow,
  input logic commitStart,
  input logic commitDone
);
  int runLen;

  always_ff @(posedge clk) begin
    if (!rstN) runLen <= 0;
    else if (busy) runLen <= runLen + 1;
    else runLen <= 0;
  end

  // R2
  start_with_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> commitStart);

  // R2
  start_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitStart |=> !commitStart);

  // R3
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (runLen == CYCLES));

  // R4
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitDone |-> (!busy && $past(busy)));

  // R4
  done_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> commitDone);

  // R6
  no_ack_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (!sdaAckLow && !ackGate));

  // R7
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (commitDone && addrMatch) |-> sdaAckLow);
endmodule

bind write_cycle_timer wct_checker #(.CYCLES(CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .addrMatch(addrMatch), .busy(busy),
  .ackGate(ackGate), .sdaAckLow(sdaAckLow),
  .commitStart(commitStart), .commitDone(commitDone)
);

// File: tb/tb_write_cycle_timer.sv
module tb_write_cycle_timer;
  localparam int CYC = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startCond = 1'b0, stopCond = 1'b0, byteWritten = 1'b0, addrMatch = 1'b0;
  logic busy, ackGate, sdaAckLow, commitStart, commitDone;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // behavioural reference
  int  mRemain = 0;
  bit  mPend = 0, mStart = 0, mDone = 0;

  always #2.5 clk = ~clk;

  write_cycle_timer #(.CYCLES(CYC)) dut (
    .clk(clk), .rstN(rstN), .startCond(startCond), .stopCond(stopCond),
    .byteWritten(byteWritten), .addrMatch(addrMatch), .busy(busy),
    .ackGate(ackGate), .sdaAckLow(sdaAckLow),
    .commitStart(commitStart), .commitDone(commitDone)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mRemain = 0; mPend = 0; mStart = 0; mDone = 0;
    end else begin
      mStart = 0; mDone = 0;
      if (mRemain > 0) begin
        mRemain = mRemain - 1;
        if (mRemain == 0) mDone = 1;
      end else if (stopCond) begin
        if (mPend) begin mRemain = CYC; mStart = 1; end
        mPend = 0;
      end else if (startCond) mPend = 0;
      else if (byteWritten) mPend = 1;
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    bit mBusy;
    mBusy = (mRemain > 0);
    chk(busy, mBusy, "R3 busy");
    chk(commitStart, mStart, "R2 commitStart");
    chk(commitDone, mDone, "R4 commitDone");
    chk(ackGate, !mBusy, mBusy ? "R6 ackGate" : "R7 ackGate");
    chk(sdaAckLow, addrMatch && !mBusy, mBusy ? "R6 sdaAckLow" : "R7 sdaAckLow");
  endtask

  // one clock: check current outputs, then drive the next inputs
  task automatic step(input bit st, input bit sp, input bit bw, input bit am);
    @(negedge clk);
    if (rstN) compareAll();
    startCond = st; stopCond = sp; byteWritten = bw; addrMatch = am;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy, 1'b0, "R1 busy");
    chk(commitStart, 1'b0, "R1 commitStart");
    chk(commitDone, 1'b0, "R1 commitDone");
    chk(sdaAckLow, 1'b0, "R1 sdaAckLow");
    chk(ackGate, 1'b1, "R1 ackGate");

    // R2 R3 R4 R7: normal write of two bytes, then poll
    step(1, 0, 0, 0); step(0, 0, 0, 1); step(0, 0, 1, 0); step(0, 0, 1, 0);
    step(0, 1, 0, 0);
    step(0, 0, 0, 0);
    chk(commitStart, 1'b1, "R2 pulse after stop");
    // R6 polling while busy
    for (int i = 0; i < CYC + 3; i++) step(i % 3 == 0, 0, 0, i % 3 == 1);
    idle(2);

    // R5 stop with no data byte
    step(1, 0, 0, 0); step(0, 0, 0, 1); step(0, 1, 0, 0); idle(2);
    chk(busy, 1'b0, "R5 no cycle without data");

    // R9 start discards pending byte
    step(1, 0, 0, 0); step(0, 0, 1, 0); step(1, 0, 0, 0); step(0, 1, 0, 0); idle(2);
    chk(busy, 1'b0, "R9 start discards bytes");

    // R8 events during busy ignored
    step(1, 0, 0, 0); step(0, 0, 1, 0); step(0, 1, 0, 0);
    step(1, 0, 0, 0); step(0, 0, 1, 0); step(0, 1, 0, 0); step(0, 0, 1, 1);
    idle(CYC);
    chk(busy, 1'b0, "R8 cycle not extended");
    step(0, 1, 0, 0); idle(2);
    chk(busy, 1'b0, "R8 byte during busy not armed");

    // mixed random traffic
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom_range(0, 9);
      step(r == 0, r == 1 || r == 2, r >= 3 && r <= 5, r >= 6 && r <= 7);
    end
    idle(CYC + 2);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule